// File: doc/BRIEF.md
# Output-Stage Fault Supervisor

This block watches two fault indications from a power output stage, one for excess temperature and one for excess current. When either one trips, it raises a fault status line and pulls the output-stage enable low, so the driver goes to high impedance. The fault inputs and the clear request arrive without a clock relationship, so each one passes through a two-flop synchronizer before use.

A mode input selects how a tripped fault recovers. In latched mode, the fault holds until a controller sends an active-low clear pulse. The pulse must be at least a minimum width, and the fault condition must already have gone away when the pulse is accepted. In retry mode, the block needs no controller. Once per retry period it re-enables the output if the condition has cleared. If the load is still shorted, the output trips again, so the enable and the fault line keep toggling at the retry rate until the short is removed.

The clock frequency, the minimum clear width and the retry period are parameters. The block converts the two times into cycle counts, rounding up.

Top module: `fault_supervisor`

## Requirements
- R1: A high level on either fault input is seen two clock edges later through the synchronizer. From then on, the fault output is high and the block stays tripped.
- R2: The drive enable is low in every cycle in which the fault output is high. This includes the first cycle in which a synchronized fault is seen.
- R3: In latched mode (mode input 0), a tripped fault stays high after the inputs return low. It clears only on an accepted clear pulse.
- R4: A clear pulse (clear input at 0) is accepted when it lasts at least ceil(CLR_MIN_NS × CLK_HZ / 1e9) cycles, which is 25 cycles at the defaults. It is judged on its rising edge. A pulse one cycle shorter has no effect.
- R5: An accepted clear pulse that ends while a fault input is still high does not clear the fault. A new pulse is needed after the input goes low.
- R6: In retry mode (mode input 1), the check comes ceil(RETRY_NS × CLK_HZ / 1e9) cycles after the trip is latched, which is 250 cycles at the defaults. If the inputs are low at that check, the block clears and re-enables. A 3-cycle fault pulse therefore holds the fault output high for exactly 251 cycles.
- R7: In retry mode, if a fault input is still high at a check, the block stays tripped and checks again one period later.
- R8: In retry mode, an over-current that reappears every time the drive is enabled makes the enable and fault output toggle once per retry period.
- R9: After the synchronous reset, the fault output is low and the drive enable is high, in both modes.
- R10: In retry mode the clear input has no effect. A long clear pulse does not shorten a trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| over_temp_i | input | 1 | Over-temperature indication, asynchronous, active high |
| over_curr_i | input | 1 | Over-current indication, asynchronous, active high |
| auto_retry_i | input | 1 | Recovery mode: 0 latched, 1 periodic retry |
| clr_req_n_i | input | 1 | Active-low clear request, asynchronous |
| fault_o | output | 1 | Fault status, high while tripped or while a synchronized fault is present |
| drv_en_o | output | 1 | Output-stage enable; low places the driver in high impedance |

## Verification
The assertions check the following on every cycle:
- the enable is low whenever the block is tripped or a synchronized fault is present;
- a synchronized fault always leads to the tripped state;
- a trip never ends while a fault is still present;
- in latched mode, a trip ends only on an accepted clear;
- in retry mode, a trip ends only on a retry tick.

The bench scenarios cover what depends on exact durations and on the closed loop with a load:
- the 25-cycle versus 24-cycle clear boundary;
- the exact 251-cycle trip length;
- the re-pulse needed after a clear that came too early;
- the toggling of the enable against a modelled short circuit.

// File: rtl/fsup_pkg.sv
`timescale 1ns/1ps
package fsup_pkg;

    localparam longint unsigned NS_PER_SEC = 64'd1_000_000_000;

    // Fault causes after synchronization
    typedef struct packed {
        logic over_temp;
        logic over_curr;
    } fsup_cause_t;

    // Supervisor state
    typedef enum logic {
        FS_ARMED   = 1'b0,
        FS_TRIPPED = 1'b1
    } fsup_state_t;

    // Convert a time in ns into clock cycles, rounded up
    function automatic int unsigned ns_to_cycles(longint unsigned clk_hz,
                                                 longint unsigned ns);
        longint unsigned prod;
        prod = clk_hz * ns;
        return 32'((prod + NS_PER_SEC - 64'd1) / NS_PER_SEC);
    endfunction

    // Lower bound on a derived count
    function automatic int unsigned at_least(int unsigned value, int unsigned floor_v);
        return (value < floor_v) ? floor_v : value;
    endfunction

endpackage

// File: rtl/fsup_sync.sv
`timescale 1ns/1ps
module fsup_sync #(
    parameter int unsigned    W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                stage1[b] <= RST_VAL[b];
                stage2[b] <= RST_VAL[b];
            end else begin
                stage1[b] <= d_async[b];
                stage2[b] <= stage1[b];
            end
        end
    end

    assign q_sync = stage2;
endmodule

// File: rtl/fsup_width_qual.sv
`timescale 1ns/1ps
module fsup_width_qual #(
    parameter int unsigned MIN_CYC = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic req_n_s,
    output logic accept
);
    localparam int unsigned CW = $clog2(MIN_CYC + 1);
    localparam logic [CW-1:0] SAT = CW'(MIN_CYC);

    logic [CW-1:0] low_cnt;
    logic          req_prev;

    // Count low cycles, saturating at the minimum width
    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt  <= '0;
            req_prev <= 1'b1;
        end else begin
            req_prev <= req_n_s;
            if (req_n_s)
                low_cnt <= '0;
            else if (low_cnt != SAT)
                low_cnt <= low_cnt + 1'b1;
        end
    end

    // Judged on the release edge
    assign accept = req_n_s && !req_prev && (low_cnt == SAT);
endmodule

// File: rtl/fsup_retry_timer.sv
`timescale 1ns/1ps
module fsup_retry_timer #(
    parameter int unsigned PERIOD = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = $clog2(PERIOD);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/fault_supervisor.sv
`timescale 1ns/1ps
module fault_supervisor
    import fsup_pkg::*;
#(
    parameter longint unsigned CLK_HZ     = 64'd250_000_000,
    parameter int unsigned     CLR_MIN_NS = 100,
    parameter int unsigned     RETRY_NS   = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic over_temp_i,
    input  logic over_curr_i,
    input  logic auto_retry_i,
    input  logic clr_req_n_i,
    output logic fault_o,
    output logic drv_en_o
);
    localparam int unsigned CLR_MIN_CYC = at_least(ns_to_cycles(CLK_HZ, 64'(CLR_MIN_NS)), 1);
    localparam int unsigned RETRY_CYC   = at_least(ns_to_cycles(CLK_HZ, 64'(RETRY_NS)), 2);

    // Synchronizers: {clear_n, over_temp, over_curr}
    logic [2:0]  raw_in;
    logic [2:0]  sync_out;
    fsup_cause_t cause_s;
    logic        clr_n_s;

    assign raw_in = {clr_req_n_i, over_temp_i, over_curr_i};

    fsup_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (raw_in),
        .q_sync  (sync_out)
    );

    assign clr_n_s           = sync_out[2];
    assign cause_s.over_temp = sync_out[1];
    assign cause_s.over_curr = sync_out[0];

    logic cause_hit;
    assign cause_hit = cause_s.over_temp | cause_s.over_curr;

    // Clear-pulse width qualification
    logic clr_accept;
    fsup_width_qual #(.MIN_CYC(CLR_MIN_CYC)) u_qual (
        .clk     (clk),
        .rst     (rst),
        .req_n_s (clr_n_s),
        .accept  (clr_accept)
    );

    // Retry timer runs only while tripped in retry mode
    fsup_state_t st, st_nx;
    logic        tripped;
    logic        retry_tick;

    assign tripped = (st == FS_TRIPPED);

    fsup_retry_timer #(.PERIOD(RETRY_CYC)) u_retry (
        .clk  (clk),
        .rst  (rst),
        .run  (auto_retry_i && tripped),
        .tick (retry_tick)
    );

    logic release_ok;
    assign release_ok = !cause_hit &&
                        ((auto_retry_i && retry_tick) || (!auto_retry_i && clr_accept));

    always_comb begin
        st_nx = st;
        unique case (st)
            FS_ARMED:   if (cause_hit)  st_nx = FS_TRIPPED;
            FS_TRIPPED: if (release_ok) st_nx = FS_ARMED;
            default:    st_nx = FS_ARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= FS_ARMED;
        else     st <= st_nx;
    end

    // Enable drops in the first cycle a synchronized fault is present
    assign fault_o  = tripped | cause_hit;
    assign drv_en_o = ~fault_o;
endmodule

// File: rtl/fsup_checks.sv
`timescale 1ns/1ps
module fsup_checks #(
    parameter int unsigned RETRY_CYC = 250
) (
    input logic clk,
    input logic rst,
    input logic auto_retry_i,
    input logic drv_en_o,
    input logic tripped,
    input logic cause_hit,
    input logic clr_accept,
    input logic retry_tick
);
    // R1
    hit_latch_chk: assert property (@(posedge clk) disable iff (rst)
        cause_hit |=> tripped);

    // R2
    en_cause_chk: assert property (@(posedge clk) disable iff (rst)
        cause_hit |-> !drv_en_o);

    // R2
    en_trip_chk: assert property (@(posedge clk) disable iff (rst)
        tripped |-> !drv_en_o);

    // R3
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!auto_retry_i && tripped && !clr_accept) |=> tripped);

    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tripped && cause_hit) |=> tripped);

    // R6
    retry_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (auto_retry_i && tripped && !retry_tick) |=> tripped);

    // R7
    tick_scope_chk: assert property (@(posedge clk) disable iff (rst)
        retry_tick |-> (auto_retry_i && tripped));

    // R9
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!tripped && drv_en_o));
endmodule

bind fault_supervisor fsup_checks #(.RETRY_CYC(RETRY_CYC)) u_fsup_checks (
    .clk          (clk),
    .rst          (rst),
    .auto_retry_i (auto_retry_i),
    .drv_en_o     (drv_en_o),
    .tripped      (tripped),
    .cause_hit    (cause_hit),
    .clr_accept   (clr_accept),
    .retry_tick   (retry_tick)
);

// File: tb/tb_fault_supervisor.sv
`timescale 1ns/1ps
module tb_fault_supervisor;
    localparam int CLR_CYC   = 25;   // ceil(100 ns * 250 MHz)
    localparam int RETRY_CYC = 250;  // ceil(1000 ns * 250 MHz)

    logic clk = 1'b0;
    logic rst;
    logic over_temp_i;
    logic oc_force;
    logic short_on;
    logic over_curr_i;
    logic auto_retry_i;
    logic clr_req_n_i;
    logic fault_o;
    logic drv_en_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    // Load model: a short draws over-current whenever the drive is enabled
    always_comb over_curr_i = oc_force | (short_on & drv_en_o);

    fault_supervisor dut (
        .clk          (clk),
        .rst          (rst),
        .over_temp_i  (over_temp_i),
        .over_curr_i  (over_curr_i),
        .auto_retry_i (auto_retry_i),
        .clr_req_n_i  (clr_req_n_i),
        .fault_o      (fault_o),
        .drv_en_o     (drv_en_o)
    );

    task automatic check(input bit ok, input string req, input int actual, input int expected);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset(input logic mode);
        @(negedge clk);
        rst = 1'b1; over_temp_i = 1'b0; oc_force = 1'b0; short_on = 1'b0;
        clr_req_n_i = 1'b1; auto_retry_i = mode;
        cycles(3);
        rst = 1'b0;
        cycles(2);
    endtask

    task automatic clr_pulse(input int width);
        clr_req_n_i = 1'b0;
        cycles(width);
        clr_req_n_i = 1'b1;
        cycles(8);
    endtask

    // R9: reset state in both modes
    task automatic t_reset_state();
        for (int m = 0; m < 2; m++) begin
            do_reset(m[0]);
            check(fault_o == 1'b0, "R9 fault after reset", fault_o, 0);
            check(drv_en_o == 1'b1, "R9 enable after reset", drv_en_o, 1);
        end
    endtask

    // R1/R2: two-edge latency, enable low in the same cycle
    task automatic t_latency();
        do_reset(1'b0);
        over_temp_i = 1'b1;
        cycles(1);
        check(fault_o == 1'b0, "R1 fault before second sync edge", fault_o, 0);
        cycles(1);
        check(fault_o == 1'b1, "R1 fault after second sync edge", fault_o, 1);
        check(drv_en_o == 1'b0, "R2 enable low same cycle", drv_en_o, 0);
        over_temp_i = 1'b0;
        do_reset(1'b0);
        oc_force = 1'b1;
        cycles(3);
        oc_force = 1'b0;
        cycles(6);
        check(fault_o == 1'b1, "R1 over-current latches", fault_o, 1);
        check(drv_en_o == 1'b0, "R2 enable low while tripped", drv_en_o, 0);
    endtask

    // R3/R4: latched hold, width boundary
    task automatic t_latched();
        do_reset(1'b0);
        over_temp_i = 1'b1;
        cycles(5);
        over_temp_i = 1'b0;
        cycles(RETRY_CYC + 20);
        check(fault_o == 1'b1, "R3 latched fault holds", fault_o, 1);
        clr_pulse(CLR_CYC - 1);
        check(fault_o == 1'b1, "R4 short clear ignored", fault_o, 1);
        check(drv_en_o == 1'b0, "R4 enable stays low", drv_en_o, 0);
        clr_pulse(CLR_CYC);
        check(fault_o == 1'b0, "R4 minimum clear accepted", fault_o, 0);
        check(drv_en_o == 1'b1, "R3 enable restored", drv_en_o, 1);
    endtask

    // R5: clear during active fault must be repeated
    task automatic t_busy_clear();
        do_reset(1'b0);
        over_temp_i = 1'b1;
        cycles(5);
        clr_pulse(CLR_CYC + 5);
        over_temp_i = 1'b0;
        cycles(10);
        check(fault_o == 1'b1, "R5 early clear ignored", fault_o, 1);
        clr_pulse(CLR_CYC + 5);
        check(fault_o == 1'b0, "R5 repeated clear works", fault_o, 0);
    endtask

    // R6: exact trip length in retry mode
    task automatic t_retry_len();
        int high = 0;
        do_reset(1'b1);
        over_temp_i = 1'b1;
        cycles(1);
        over_temp_i = 1'b0;
        cycles(2);
        over_temp_i = 1'b0;
        high = 0;
        // restart with a clean 3-cycle pulse
        do_reset(1'b1);
        over_temp_i = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (fault_o) high++;
        end
        over_temp_i = 1'b0;
        for (int i = 0; i < RETRY_CYC + 100; i++) begin
            @(negedge clk);
            if (fault_o) high++;
        end
        check(high == RETRY_CYC + 1, "R6 trip length", high, RETRY_CYC + 1);
        check(drv_en_o == 1'b1, "R6 re-enabled", drv_en_o, 1);
    endtask

    // R7: persistent fault stays tripped, clears after removal
    task automatic t_retry_hold();
        int high = 0;
        do_reset(1'b1);
        over_temp_i = 1'b1;
        cycles(3);
        for (int i = 0; i < 3 * RETRY_CYC; i++) begin
            @(negedge clk);
            if (fault_o) high++;
        end
        check(high == 3 * RETRY_CYC, "R7 held across checks", high, 3 * RETRY_CYC);
        over_temp_i = 1'b0;
        cycles(RETRY_CYC + 10);
        check(fault_o == 1'b0, "R7 cleared at later check", fault_o, 0);
    endtask

    // R8: oscillation against a short
    task automatic t_oscillate();
        int rises = 0;
        logic prev;
        do_reset(1'b1);
        short_on = 1'b1;
        prev = drv_en_o;
        for (int i = 0; i < 4 * RETRY_CYC; i++) begin
            @(negedge clk);
            if (drv_en_o && !prev) rises++;
            prev = drv_en_o;
        end
        check(rises >= 3, "R8 enable toggles at retry rate", rises, 3);
        check(rises <= 4, "R8 toggle count bounded", rises, 4);
        short_on = 1'b0;
        cycles(RETRY_CYC + 10);
        check(drv_en_o == 1'b1, "R8 stable after short removed", drv_en_o, 1);
    endtask

    // R10: clear input ignored in retry mode
    task automatic t_auto_clr();
        do_reset(1'b1);
        over_temp_i = 1'b1;
        cycles(3);
        over_temp_i = 1'b0;
        cycles(10);
        clr_pulse(CLR_CYC + 15);
        check(fault_o == 1'b1, "R10 clear ignored in retry mode", fault_o, 1);
        cycles(RETRY_CYC);
        check(fault_o == 1'b0, "R10 retry still clears", fault_o, 0);
    endtask

    initial begin
        rst = 1'b1; over_temp_i = 1'b0; oc_force = 1'b0; short_on = 1'b0;
        clr_req_n_i = 1'b1; auto_retry_i = 1'b0;
        t_reset_state();
        t_latency();
        t_latched();
        t_busy_clear();
        t_retry_len();
        t_retry_hold();
        t_oscillate();
        t_auto_clr();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule